// File: doc/BRIEF.md
# Interrupt Enable and Priority Arbiter

This block keeps an enable bit and a 4-bit priority level for each of up to 96 interrupt request lines. On every cycle it looks at the lines that are both pending and enabled and picks one winner. A lower priority value beats a higher one, and on equal values the lower line number wins. It offers that winner to a processor only when the winner's level is strictly below the processor's current execution level, so a request cannot preempt work of equal or more urgent priority.

Software uses a 32-bit register port with byte offsets. Enables are changed through two word banks that share one store. Writing a 1 into a set-bank bit turns that line on. Writing a 1 into the matching clear-bank bit turns it off. A 0 bit leaves its line as it was. Priorities are packed four to a word, one byte per line. Each byte keeps only its upper nibble. The winner search is registered, so the request outputs describe the inputs and state of the previous cycle.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every enable and every priority is 0, and reqValid is 0.
- R2: A write to set-bank offset 0x00, 0x04 or 0x08 enables line 32*w+b for each 1 in data bit b, where w is the word index (offset/4). Bits written as 0 keep their value. The new state is visible from the next cycle.
- R3: A write to clear-bank offset 0x80, 0x84 or 0x88 disables line 32*w+b for each 1 in data bit b. Bits written as 0 keep their value.
- R4: A read of either the set-bank or the clear-bank word w returns the enable state of lines 32*w to 32*w+31, with line 32*w+b in bit b.
- R5: The priority of line n is held in the word at offset 0x100+4*(n/4). It sits in bits [8k+7:8k+4] of that word, where k=n%4. The bits [8k+3:8k] read as 0, and writes to them are ignored.
- R6: Only lines that are both pending and enabled take part in the search. With no such line, reqValid is 0.
- R7: The winner is the candidate with the numerically lowest priority. Among equal priorities, the lowest line number wins. reqId and reqPrio give that line and its priority.
- R8: reqValid is 1 only when the winner's priority is strictly less than curPrio.
- R9: The request outputs are registered. A change on irqPending or curPrio shows at the outputs after the next rising clock edge.
- R10: Writes to unmapped offsets leave all state unchanged, and reads of them return 0. Unmapped offsets include 0x0C, 0x8C, and priority words beyond the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 10 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqPending | input | 96 | Pending request lines |
| curPrio | input | 4 | Priority of the code currently executing |
| reqValid | output | 1 | A preempting request is offered |
| reqId | output | 7 | Winning line number |
| reqPrio | output | 4 | Winning line priority |

## Verification
The assertions assume that busWr is a single clean strobe with a word-aligned offset. They also assume that irqPending and curPrio are stable around the rising edge. The bench meets both by changing every input only on the falling edge and by writing only aligned offsets, mapped or deliberately unmapped. The gating check relies on curPrio from the cycle before a request is offered, and the bench holds curPrio steady across each arbitration step.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;

  typedef enum logic [1:0] {RD_NONE = 2'd0, RD_EN = 2'd1, RD_PRIO = 2'd2} rdKind_e;

  typedef struct packed {
    logic              setWr;
    logic              clrWr;
    logic              prioWr;
    rdKind_e           rdKind;
    logic [IDX_W-1:0]  wordIdx;
    logic [DATA_W-1:0] data;
  } busStrobe_t;
endpackage

// File: rtl/irq_bus_ctrl.sv
module irq_bus_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output busStrobe_t        strobe
);
  localparam int EN_WORDS   = (NUM_IRQ + 31) / 32;
  localparam int PRIO_WORDS = (NUM_IRQ + 3) / 4;

  logic [2:0]       region;
  logic [IDX_W-1:0] idx;
  logic             enHit, clrHit, prioHit;

  always_comb begin
    region  = busAddr[ADDR_W-1 -: 3];
    idx     = (region[2:1] == 2'b00) ? {1'b0, busAddr[6:2]} : busAddr[7:2];
    enHit   = (region == 3'd0) && (int'(idx) < EN_WORDS);
    clrHit  = (region == 3'd1) && (int'(idx) < EN_WORDS);
    prioHit = (region[2:1] == 2'b01) && (int'(idx) < PRIO_WORDS);

    strobe.setWr   = busWr && enHit;
    strobe.clrWr   = busWr && clrHit;
    strobe.prioWr  = busWr && prioHit;
    strobe.wordIdx = idx;
    strobe.data    = busWdata;
    if (enHit || clrHit)  strobe.rdKind = RD_EN;
    else if (prioHit)     strobe.rdKind = RD_PRIO;
    else                  strobe.rdKind = RD_NONE;
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setWr, strobe.clrWr, strobe.prioWr}));

  // R10
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setWr || strobe.clrWr || strobe.prioWr) |-> busWr);
endmodule

// File: rtl/irq_state_dp.sv
module irq_state_dp
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ   = 96,
  parameter int PRIO_BITS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  busStrobe_t                     strobe,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_IRQ-1:0]             enables,
  output logic [NUM_IRQ*PRIO_BITS-1:0]   prioFlat
);
  localparam int EN_WORDS = (NUM_IRQ + 31) / 32;
  localparam int EN_BITS  = EN_WORDS * 32;
  localparam int LSB_OFF  = 8 - PRIO_BITS;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enables[i] <= 1'b0;
      end else if (strobe.setWr && strobe.wordIdx == IDX_W'(i / 32) && strobe.data[i % 32]) begin
        enables[i] <= 1'b1;
      end else if (strobe.clrWr && strobe.wordIdx == IDX_W'(i / 32) && strobe.data[i % 32]) begin
        enables[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioFlat[i*PRIO_BITS +: PRIO_BITS] <= '0;
      end else if (strobe.prioWr && strobe.wordIdx == IDX_W'(i / 4)) begin
        prioFlat[i*PRIO_BITS +: PRIO_BITS] <= strobe.data[8*(i%4) + LSB_OFF +: PRIO_BITS];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdKind)
      RD_EN: begin
        for (int j = 0; j < 32; j++) begin
          if (int'(strobe.wordIdx) * 32 + j < NUM_IRQ)
            rdData[j] = enables[int'(strobe.wordIdx) * 32 + j];
        end
      end
      RD_PRIO: begin
        for (int b = 0; b < 4; b++) begin
          if (int'(strobe.wordIdx) * 4 + b < NUM_IRQ)
            rdData[8*b + LSB_OFF +: PRIO_BITS] =
              prioFlat[(int'(strobe.wordIdx) * 4 + b) * PRIO_BITS +: PRIO_BITS];
        end
      end
      default: rdData = '0;
    endcase
  end

  logic [EN_BITS-1:0] enFull, wrMask;
  always_comb begin
    enFull = EN_BITS'(enables);
    wrMask = (EN_BITS'(strobe.data) << {strobe.wordIdx, 5'b0}) & EN_BITS'({NUM_IRQ{1'b1}});
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setWr |=> ((enFull & $past(wrMask)) == $past(wrMask)));

  // R2
  en_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setWr || strobe.clrWr) |=> ((enFull & ~$past(wrMask)) == ($past(enFull) & ~$past(wrMask))));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrWr |=> ((enFull & $past(wrMask)) == '0));

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setWr || strobe.clrWr) |=> $stable(enables));
endmodule

// File: rtl/irq_winner_sel.sv
module irq_winner_sel #(
  parameter  int NUM_IRQ   = 96,
  parameter  int PRIO_BITS = 4,
  localparam int ID_W      = $clog2(NUM_IRQ)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_IRQ-1:0]           irqPending,
  input  logic [NUM_IRQ-1:0]           enables,
  input  logic [NUM_IRQ*PRIO_BITS-1:0] prioFlat,
  input  logic [PRIO_BITS-1:0]         curPrio,
  output logic                         reqValid,
  output logic [ID_W-1:0]              reqId,
  output logic [PRIO_BITS-1:0]         reqPrio
);
  logic [NUM_IRQ-1:0]   cand;
  logic                 found;
  logic [PRIO_BITS-1:0] bestPrio;
  logic [ID_W-1:0]      bestId;

  always_comb begin
    cand     = irqPending & enables;
    found    = 1'b0;
    bestPrio = '1;
    bestId   = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!found || prioFlat[i*PRIO_BITS +: PRIO_BITS] < bestPrio)) begin
        found    = 1'b1;
        bestPrio = prioFlat[i*PRIO_BITS +: PRIO_BITS];
        bestId   = ID_W'(i);
      end
    end
  end

  logic [NUM_IRQ-1:0] candQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      reqId    <= '0;
      reqPrio  <= '0;
      candQ    <= '0;
    end else begin
      reqValid <= found && (bestPrio < curPrio);
      reqId    <= found ? bestId : '0;
      reqPrio  <= found ? bestPrio : '0;
      candQ    <= cand;
    end
  end

  // R8
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqPrio < $past(curPrio)));

  // R6
  req_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> candQ[reqId]);

  // R6
  req_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (candQ == '0) |-> !reqValid);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter  int NUM_IRQ   = 96,
  parameter  int PRIO_BITS = 4,
  localparam int ID_W      = $clog2(NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_IRQ-1:0]   irqPending,
  input  logic [PRIO_BITS-1:0] curPrio,
  output logic                 reqValid,
  output logic [ID_W-1:0]      reqId,
  output logic [PRIO_BITS-1:0] reqPrio
);
  busStrobe_t                   strobe;
  logic [NUM_IRQ-1:0]           enables;
  logic [NUM_IRQ*PRIO_BITS-1:0] prioFlat;

  irq_bus_ctrl #(.NUM_IRQ(NUM_IRQ)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe)
  );

  irq_state_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(busRdata),
    .enables(enables), .prioFlat(prioFlat)
  );

  irq_winner_sel #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) sel_i (
    .clk(clk), .rstN(rstN), .irqPending(irqPending), .enables(enables),
    .prioFlat(prioFlat), .curPrio(curPrio), .reqValid(reqValid),
    .reqId(reqId), .reqPrio(reqPrio)
  );
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [95:0] irqPending = '0;
  logic [3:0]  curPrio = 4'hF;
  logic        reqValid;
  logic [6:0]  reqId;
  logic [3:0]  reqPrio;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_arbiter dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqPending(irqPending),
    .curPrio(curPrio), .reqValid(reqValid), .reqId(reqId), .reqPrio(reqPrio)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [9:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic regRead(input logic [9:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1;
    data = busRdata;
  endtask

  task automatic checkReq(input string req, input logic v, input logic [6:0] id, input logic [3:0] p);
    check({req, " valid"}, 32'(reqValid), 32'(v));
    if (v) begin
      check({req, " id"}, 32'(reqId), 32'(id));
      check({req, " prio"}, 32'(reqPrio), 32'(p));
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 reqValid", 32'(reqValid), 0);
    regRead(10'h008, d); check("R1 enable word2", d, 0);
    regRead(10'h15C, d); check("R1 prio word23", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    regWrite(10'h000, 32'h0000_0021);
    regWrite(10'h008, 32'h8000_0000);
    regRead(10'h000, d); check("R2 set word0", d, 32'h0000_0021);
    regRead(10'h080, d); check("R4 clear-bank read", d, 32'h0000_0021);
    regRead(10'h008, d); check("R2 set word2 line95", d, 32'h8000_0000);
    regWrite(10'h000, 32'h0000_0002);
    regRead(10'h000, d); check("R2 zeros keep", d, 32'h0000_0023);
    regWrite(10'h080, 32'h0000_0001);
    regRead(10'h000, d); check("R3 clear line0", d, 32'h0000_0022);
    regRead(10'h088, d); check("R3 other word kept", d, 32'h8000_0000);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    regWrite(10'h100, 32'hFFFF_FFFF);
    regRead(10'h100, d); check("R5 low nibble zero", d, 32'hF0F0_F0F0);
    regWrite(10'h100, 32'h0000_5A00);
    regRead(10'h100, d); check("R5 line1 byte1", d, 32'h0000_5000);
    regWrite(10'h104, 32'h0000_5000);
    regWrite(10'h15C, 32'h2000_0000);
    regRead(10'h15C, d); check("R5 line95 byte3", d, 32'h2000_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    regWrite(10'h00C, 32'hFFFF_FFFF);
    regWrite(10'h08C, 32'hFFFF_FFFF);
    regWrite(10'h160, 32'hFFFF_FFFF);
    regRead(10'h00C, d); check("R10 enable word3 reads 0", d, 0);
    regRead(10'h160, d); check("R10 prio word24 reads 0", d, 0);
    regRead(10'h000, d); check("R10 word0 unchanged", d, 32'h0000_0022);
    regRead(10'h15C, d); check("R10 word23 unchanged", d, 32'h2000_0000);
  endtask

  task automatic t_arb();
    curPrio = 4'hF;
    irqPending = '0; settle();
    checkReq("R6 nothing pending", 0, 0, 0);
    irqPending = 96'd1 << 3; settle();
    checkReq("R6 pending not enabled", 0, 0, 0);
    irqPending = (96'd1 << 1) | (96'd1 << 5); settle();
    checkReq("R7 tie lower id", 1, 7'd1, 4'd5);
    irqPending = (96'd1 << 1) | (96'd1 << 5) | (96'd1 << 95); settle();
    checkReq("R7 lowest prio wins", 1, 7'd95, 4'd2);
    curPrio = 4'd2; settle();
    checkReq("R8 equal blocked", 0, 0, 0);
    curPrio = 4'd3; settle();
    checkReq("R8 lower offered", 1, 7'd95, 4'd2);
  endtask

  task automatic t_latency();
    curPrio = 4'hF;
    irqPending = '0; settle();
    checkReq("R9 idle", 0, 0, 0);
    irqPending = 96'd1 << 5;
    #1;
    checkReq("R9 not before edge", 0, 0, 0);
    settle();
    checkReq("R9 after edge", 1, 7'd5, 4'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    t_reset();
    t_enable();
    t_prio();
    t_unmapped();
    t_arb();
    t_latency();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule